// File: doc/BRIEF.md
# FM Synthesiser Register Write Front-End

This block sits between a host bus and the global control logic of an FM sound generator. The host writes bytes through a four-location port. Port bit 0 chooses between an address write (even) and a data write (odd). Port bit 1 chooses the upper register bank.

Each write is captured into a 9-bit word: the bank bit on top of the byte. The request then passes through a two-stage shift register, and the write is acted on one cycle late. A data write raises a busy flag for a fixed window.

Address writes are latched as FM register addresses. The exception is an address whose upper nibble is zero: that one only marks an access to the SSG range. Data writes to the lower-bank global registers are decoded into fields for the timers, the LFO, key-on logic, the DAC and the test controls.

Top module: `fm_wr_front`

## Requirements
- R1: A host write sampled at clock edge E0 takes effect on the outputs at edge E0+1. Only the first cycle of a request held high on consecutive cycles is accepted, using the byte captured at E0. Before E0+1 the outputs keep their old value.
- R2: An accepted data write sets `busy` at the next edge, and `busy` then stays high for exactly BUSY_CYCLES (32) cycles. A data write accepted while busy restarts the full window.
- R3: An address write with byte bits 7:4 non-zero has its effect at the edge where the write is accepted (R1 timing):
  - `addr` is loaded with {port bit 1, byte};
  - `addr_valid` is set and `ssg_hit` is cleared.
  An address write with byte bits 7:4 equal to zero clears `addr_valid`, sets `ssg_hit`, and leaves `addr` unchanged.
- R4: A data write to address 0x24 loads the byte into timer A bits 9:2 and keeps bits 1:0. A data write to 0x25 loads byte bits 1:0 into timer A bits 1:0 and keeps bits 9:2.
- R5: A data write to 0x26 loads the byte into the 8-bit timer B value.
- R6: A data write to 0x28 drives the operator key bits from byte bits 7:4. The channel code is byte bits 1:0 plus 3 when byte bit 2 is set, giving 0..5. When byte bits 1:0 equal 3, the channel code is 7 (all ones).
- R7: A data write to 0x22 sets the LFO enable from byte bit 3 and the LFO frequency index from byte bits 2:0.
- R8: A data write to 0x2A loads the byte into DAC bits 8:1 and keeps bit 0. A data write to 0x2B sets the DAC enable from byte bit 7.
- R9: A data write is decoded only when all three hold: its port bit 1 is zero, the latched address has bit 8 zero, and `addr_valid` is set. Otherwise no decoded output changes.
- R10: After reset every decoded output is zero, `addr_valid`, `ssg_hit` and `busy` are low, and `addr` is zero.
- R11: A data write to 0x27 decodes the following byte bits:
  - bits 7:6: channel-3 mode;
  - bit 0: timer A load;
  - bit 1: timer B load;
  - bit 2: timer A flag enable;
  - bit 3: timer B flag enable.
  Byte bits 4 and 5 produce one-cycle clear pulses for timer A and timer B.
- R12: Data writes to 0x21 and 0x2C load the byte into the first and second test registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write request |
| wr_port | input | 2 | Bit 0: data (1) or address (0); bit 1: upper bank |
| wr_byte | input | 8 | Write byte |
| busy | output | 1 | Busy after a data write |
| addr_valid | output | 1 | Latched address is an FM address |
| ssg_hit | output | 1 | Last address write selected the SSG range |
| addr | output | 9 | Latched address {bank, byte} |
| test_a | output | 8 | First test register |
| test_b | output | 8 | Second test register |
| lfo_en | output | 1 | LFO enable |
| lfo_freq | output | 3 | LFO frequency index |
| tmra_val | output | 10 | Timer A value |
| tmrb_val | output | 8 | Timer B value |
| ch3_mode | output | 2 | Channel-3 mode |
| tmra_load | output | 1 | Timer A load/run |
| tmrb_load | output | 1 | Timer B load/run |
| tmra_flag_en | output | 1 | Timer A flag enable |
| tmrb_flag_en | output | 1 | Timer B flag enable |
| tmra_clr | output | 1 | Timer A clear pulse |
| tmrb_clr | output | 1 | Timer B clear pulse |
| kon_ops | output | 4 | Operator key bits |
| kon_chan | output | 3 | Key-on channel code, 7 = invalid |
| dac_val | output | 9 | DAC sample |
| dac_en | output | 1 | DAC enable |

## Verification
The hardest case to reach from the ports is a request held for two consecutive cycles. The shift register then reads 01 followed by 11, and the captured byte is overwritten before the decode edge. The stimulus holds `wr_en` for two clocks with different bytes, and checks that only the first byte lands and that it lands no earlier than one edge after capture.

The busy restart is reached by issuing a second data write part-way through the window, then counting the remaining busy cycles.

The gating cases use three stimuli:
- an SSG-range address write;
- an upper-bank address write;
- an upper-bank data write.
Each is followed by a read-back of the timer B value, which must be unchanged.

// File: rtl/fm_wr_front.sv
module fm_wr_front #(
  parameter int BUSY_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_port,
  input  logic [7:0] wr_byte,
  output logic       busy,
  output logic       addr_valid,
  output logic       ssg_hit,
  output logic [8:0] addr,
  output logic [7:0] test_a,
  output logic [7:0] test_b,
  output logic       lfo_en,
  output logic [2:0] lfo_freq,
  output logic [9:0] tmra_val,
  output logic [7:0] tmrb_val,
  output logic [1:0] ch3_mode,
  output logic       tmra_load,
  output logic       tmrb_load,
  output logic       tmra_flag_en,
  output logic       tmrb_flag_en,
  output logic       tmra_clr,
  output logic       tmrb_clr,
  output logic [3:0] kon_ops,
  output logic [2:0] kon_chan,
  output logic [8:0] dac_val,
  output logic       dac_en
);
  localparam int CW = $clog2(BUSY_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(BUSY_CYCLES - 1);

  logic [1:0]    sa, sd;
  logic [8:0]    wd;
  logic [CW-1:0] cnt;
  logic          ena, den, hit;

  assign ena = (sa == 2'b01);
  assign den = (sd == 2'b01);
  assign hit = den & ~wd[8] & addr_valid & ~addr[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa <= '0;
      sd <= '0;
      wd <= '0;
    end else begin
      sa <= {sa[0], wr_en & ~wr_port[0]};
      sd <= {sd[0], wr_en & wr_port[0]};
      if (wr_en) wd <= {wr_port[1], wr_byte};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (den) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CNT_LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      ssg_hit    <= 1'b0;
      addr       <= '0;
    end else if (ena) begin
      if (wd[7:4] != 4'h0) begin
        addr       <= wd;
        addr_valid <= 1'b1;
        ssg_hit    <= 1'b0;
      end else begin
        addr_valid <= 1'b0;
        ssg_hit    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_a       <= '0;
      test_b       <= '0;
      lfo_en       <= 1'b0;
      lfo_freq     <= '0;
      tmra_val     <= '0;
      tmrb_val     <= '0;
      ch3_mode     <= '0;
      tmra_load    <= 1'b0;
      tmrb_load    <= 1'b0;
      tmra_flag_en <= 1'b0;
      tmrb_flag_en <= 1'b0;
      tmra_clr     <= 1'b0;
      tmrb_clr     <= 1'b0;
      kon_ops      <= '0;
      kon_chan     <= '0;
      dac_val      <= '0;
      dac_en       <= 1'b0;
    end else begin
      tmra_clr <= 1'b0;
      tmrb_clr <= 1'b0;
      if (hit) begin
        case (addr[7:0])
          8'h21: test_a <= wd[7:0];
          8'h22: begin
            lfo_en   <= wd[3];
            lfo_freq <= wd[2:0];
          end
          8'h24: tmra_val[9:2] <= wd[7:0];
          8'h25: tmra_val[1:0] <= wd[1:0];
          8'h26: tmrb_val <= wd[7:0];
          8'h27: begin
            ch3_mode     <= wd[7:6];
            tmra_load    <= wd[0];
            tmrb_load    <= wd[1];
            tmra_flag_en <= wd[2];
            tmrb_flag_en <= wd[3];
            tmra_clr     <= wd[4];
            tmrb_clr     <= wd[5];
          end
          8'h28: begin
            kon_ops  <= wd[7:4];
            kon_chan <= (wd[1:0] == 2'b11) ? 3'b111
                      : ({1'b0, wd[1:0]} + (wd[2] ? 3'd3 : 3'd0));
          end
          8'h2A: dac_val[8:1] <= wd[7:0];
          8'h2B: dac_en <= wd[7];
          8'h2C: test_b <= wd[7:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fm_wr_front_chk.sv
module fm_wr_front_chk #(
  parameter int BUSY_CYCLES = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       den,
  input logic       busy,
  input logic       addr_valid,
  input logic [8:0] addr,
  input logic [2:0] kon_chan,
  input logic [7:0] tmrb_val,
  input logic [9:0] tmra_val,
  input logic       tmra_clr
);
  localparam int RW = $clog2(BUSY_CYCLES) + 2;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (den) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;
  end

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n) den |=> busy); // R2
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) run <= RW'(BUSY_CYCLES)); // R2
  AST_FM_ADDR: assert property (@(posedge clk) disable iff (!rst_n) addr_valid |-> addr[7:4] != 4'h0); // R3
  AST_CHAN_CODE: assert property (@(posedge clk) disable iff (!rst_n) kon_chan != 3'd6); // R6
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !den |=> $stable(tmrb_val) && $stable(tmra_val)); // R1
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tmra_clr |=> !tmra_clr); // R11
endmodule

bind fm_wr_front fm_wr_front_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (.*);

// File: tb/sim_fm_wr_front.sv
`timescale 1ns/1ps
module sim_fm_wr_front;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_port = 0;
  logic [7:0] wr_byte = 0;
  logic busy, addr_valid, ssg_hit, lfo_en, tmra_load, tmrb_load;
  logic tmra_flag_en, tmrb_flag_en, tmra_clr, tmrb_clr, dac_en;
  logic [8:0] addr, dac_val;
  logic [7:0] test_a, test_b, tmrb_val;
  logic [2:0] lfo_freq, kon_chan;
  logic [9:0] tmra_val;
  logic [1:0] ch3_mode;
  logic [3:0] kon_ops;

  fm_wr_front u0 (.*);

  always #10 clk = ~clk;

  typedef struct { int sel; int exp; string req; } item_t;
  item_t q[$];
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic int getval(int sel);
    case (sel)
      0: return int'(busy);       1: return int'(addr_valid);
      2: return int'(ssg_hit);    3: return int'(addr);
      4: return int'(test_a);     5: return int'(test_b);
      6: return int'(lfo_en);     7: return int'(lfo_freq);
      8: return int'(tmra_val);   9: return int'(tmrb_val);
      10: return int'(ch3_mode);  11: return int'(tmra_load);
      12: return int'(tmrb_load); 13: return int'(tmra_flag_en);
      14: return int'(tmrb_flag_en); 15: return int'(tmra_clr);
      16: return int'(tmrb_clr);  17: return int'(kon_ops);
      18: return int'(kon_chan);  19: return int'(dac_val);
      20: return int'(dac_en);
      default: return -1;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_v(int sel, int exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.req, getval(it.sel), it.exp);
    end
  end

  // Issues one write; returns just after the edge where it takes effect.
  task automatic raw_write(logic [1:0] p, logic [7:0] b);
    @(negedge clk);
    wr_en = 1; wr_port = p; wr_byte = b;
    @(negedge clk);
    wr_en = 0;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] p, logic [7:0] b);
    raw_write(p, b);
    @(negedge clk);
  endtask

  task automatic reg_wr(logic [7:0] a, logic [7:0] d);
    wr(2'd0, a);
    raw_write(2'd1, d);
  endtask

  task automatic gap();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic count_busy(int exp, string req);
    int n = 0;
    @(negedge clk);
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk(req, n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s <= 20; s++) expect_v(s, 0, "R10 reset");
    gap();

    reg_wr(8'h24, 8'hAB); expect_v(8, 10'h2AC, "R4 tmra hi"); gap();
    reg_wr(8'h25, 8'h03); expect_v(8, 10'h2AF, "R4 tmra lo"); gap();
    reg_wr(8'h24, 8'h01); expect_v(8, 10'h007, "R4 tmra hi keep lo"); gap();

    reg_wr(8'h26, 8'h5A); expect_v(9, 8'h5A, "R5 tmrb"); gap();

    reg_wr(8'h28, 8'hF6); expect_v(17, 4'hF, "R6 ops"); expect_v(18, 5, "R6 chan upper"); gap();
    reg_wr(8'h28, 8'h13); expect_v(17, 4'h1, "R6 ops"); expect_v(18, 7, "R6 chan invalid"); gap();
    reg_wr(8'h28, 8'h52); expect_v(18, 2, "R6 chan lower"); gap();

    reg_wr(8'h22, 8'h0D); expect_v(6, 1, "R7 lfo en"); expect_v(7, 5, "R7 lfo freq"); gap();
    reg_wr(8'h22, 8'h06); expect_v(6, 0, "R7 lfo off"); expect_v(7, 6, "R7 lfo freq"); gap();

    reg_wr(8'h2A, 8'hFF); expect_v(19, 9'h1FE, "R8 dac val"); gap();
    reg_wr(8'h2B, 8'h80); expect_v(20, 1, "R8 dac en"); gap();
    reg_wr(8'h2B, 8'h7F); expect_v(20, 0, "R8 dac off"); gap();

    reg_wr(8'h27, 8'hB5);
    expect_v(10, 2, "R11 ch3"); expect_v(11, 1, "R11 load a"); expect_v(12, 0, "R11 load b");
    expect_v(13, 1, "R11 flag a"); expect_v(14, 0, "R11 flag b");
    expect_v(15, 1, "R11 clr a"); expect_v(16, 1, "R11 clr b");
    @(negedge clk); @(posedge clk); #1;
    expect_v(15, 0, "R11 clr a pulse"); expect_v(16, 0, "R11 clr b pulse"); gap();

    reg_wr(8'h21, 8'h5C); expect_v(4, 8'h5C, "R12 test a"); gap();
    reg_wr(8'h2C, 8'hC3); expect_v(5, 8'hC3, "R12 test b"); gap();

    // R3 / R9: SSG range address
    wr(2'd0, 8'h26); expect_v(3, 9'h026, "R3 addr"); expect_v(1, 1, "R3 valid");
    raw_write(2'd0, 8'h0F); expect_v(1, 0, "R3 ssg invalid"); expect_v(2, 1, "R3 ssg hit");
    expect_v(3, 9'h026, "R3 addr kept"); gap();
    raw_write(2'd1, 8'h99); expect_v(9, 8'h5A, "R9 ssg gated"); gap();
    // upper-bank address
    wr(2'd2, 8'h26); expect_v(3, 9'h126, "R3 bank addr"); expect_v(2, 0, "R3 ssg clr");
    raw_write(2'd3, 8'h77); expect_v(9, 8'h5A, "R9 upper addr gated"); gap();
    // upper-bank data
    wr(2'd0, 8'h26);
    raw_write(2'd3, 8'h66); expect_v(9, 8'h5A, "R9 upper data gated"); gap();

    // R1: held request, latency
    @(negedge clk);
    wr_en = 1; wr_port = 2'd1; wr_byte = 8'h11;
    @(negedge clk);
    wr_byte = 8'h22;
    chk("R1 before effect", int'(tmrb_val), 8'h5A);
    @(negedge clk);
    wr_en = 0;
    chk("R1 first byte", int'(tmrb_val), 8'h11);
    gap();
    chk("R1 single accept", int'(tmrb_val), 8'h11);
    repeat (40) @(negedge clk);

    // R2: busy window and restart
    raw_write(2'd1, 8'h11);
    chk("R2 busy set", int'(busy), 1);
    count_busy(32, "R2 busy length");
    raw_write(2'd1, 8'h12);
    repeat (10) @(negedge clk);
    raw_write(2'd1, 8'h13);
    count_busy(32, "R2 busy restart");
    chk("R2 busy low", int'(busy), 0);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule